// File: doc/BRIEF.md
# Fractional-N Four-Modulus Feedback Divider Controller

This block controls the feedback path of a fractional-N frequency synthesizer. It runs on the output clock of an external multi-modulus prescaler and drives two modulus-select lines back to that prescaler. The prescaler then divides the oscillator by P, P+1, P+4 or P+5 on each of its output cycles. The base P is 16 or 8, chosen by a band input. The controller takes a 15-bit integer divide value N, a 4-bit fractional numerator and a 4-bit denominator code. It produces one pulse for every complete division of the oscillator.

Each division is split into a count of C prescaler cycles. The +1 select is active for the first A of those cycles and the +4 select for the first B. The division therefore spans P·C + 4·B + A oscillator cycles, which equals N. A fractional accumulator adds the numerator once per division, modulo the denominator. When it wraps, that division is one oscillator cycle longer. Over a full accumulator period the average ratio is N + numerator/denominator.

New settings are sampled only at the boundary between divisions. A setting that cannot be divided correctly raises an error flag, and the divider then stays idle.

Top module: `fnd_top`

## Requirements
- R1: With sub-counts C = N div P, B = (N mod P) div 4 and A = N mod 4, a division lasts C prescaler cycles. mod_p1 is high in the first A cycles and mod_p4 is high in the first B cycles. Neither select rises in the middle of a division.
- R2: band_hi = 1 selects base P = 16 and band_hi = 0 selects P = 8. Each prescaler cycle counts P + mod_p1 + 4·mod_p4 oscillator cycles.
- R3: A setting is legal only when C ≥ max(A, B) + 2. While the sampled setting is illegal, cfg_err is 1 and div_out, mod_p1 and mod_p4 stay 0. Once a legal setting is applied, division resumes without a reset.
- R4: In base 16, every N from 80 to 32767 divides correctly and 79 is rejected. In base 8, every N from 40 to 16383 divides correctly, 39 is rejected, and any N above 16383 is rejected.
- R5: Denominator code 0 means modulus 16 and codes 9 to 15 mean their own value. Codes 1 to 8 are rejected, and so is a numerator not below the modulus.
- R6: At each division boundary the numerator is added to the accumulator. When the sum reaches the modulus, the modulus is subtracted and that division lasts N+1 oscillator cycles. swallow is high for the whole of that division.
- R7: Any run of D consecutive divisions, with D the modulus, spans exactly D·N + numerator oscillator cycles.
- R8: A numerator of 0 gives pure integer-N division: every division is N cycles long and swallow never rises.
- R9: While rst is 1 at a clock edge, the counters, the accumulator and all outputs are cleared.
- R10: A change to N, numerator, denominator or band during a division does not affect that division. It takes effect from the next division.
- R11: div_out is high for exactly one prescaler cycle, the last cycle of each division.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output clock |
| rst | input | 1 | Synchronous reset, active high |
| band_hi | input | 1 | 1: base 16, 0: base 8 |
| n_word | input | 15 | Integer divide value N |
| frac_num | input | 4 | Fractional numerator |
| den_code | input | 4 | Fractional modulus code (0 = 16, 9..15 face value) |
| mod_p1 | output | 1 | Prescaler +1 modulus select |
| mod_p4 | output | 1 | Prescaler +4 modulus select |
| div_out | output | 1 | One-cycle pulse ending each division |
| swallow | output | 1 | Current division carries the extra oscillator cycle |
| cfg_err | output | 1 | Sampled setting is illegal; divider idle |

## Verification
The bench drives a behavioural prescaler that adds up oscillator cycles from the select lines. It compares single divisions and full accumulator periods against N and D·N + numerator, including the extreme values 80/32767 in base 16 and 40/16383 in base 8. A wrong sub-count split or a select held one cycle too long would show up as a length error of 1 or 4 cycles. An accumulator that wraps at the wrong modulus would give the wrong number of swallows per period.

Values just below the legal range, a setting that breaks the C ≥ max(A, B) + 2 rule, and rejected denominator codes must leave the outputs silent. A checker that was too lax would instead emit pulses with corrupted lengths. The bench also changes N in the middle of a division. A design that picked up the new value early would produce a division with a length that matches neither setting.

// File: rtl/fnd_pkg.sv
package fnd_pkg;

    localparam int NW     = 15;            // integer divide value width
    localparam int FW     = 4;             // numerator / denominator code width
    localparam int P_HI   = 16;            // prescaler base, band_hi = 1
    localparam int P_LO   = 8;             // prescaler base, band_hi = 0
    localparam int LH     = $clog2(P_HI);
    localparam int LL     = $clog2(P_LO);
    localparam int STEP   = 4;             // size of the large modulus step
    localparam int LS     = $clog2(STEP);
    localparam int SW     = LH - LS;       // B sub-count width
    localparam int CW     = NW + 1 - LL;   // C count width (covers N + 1)

    typedef struct packed {
        logic          run;
        logic          err;
        logic          swl;
        logic [CW-1:0] k;
        logic [CW-1:0] c;
        logic [SW-1:0] b;
        logic [LS-1:0] a;
        logic [FW-1:0] acc;
    } dv_state_t;

endpackage

// File: rtl/fnd_split.sv
module fnd_split #(
    parameter int VW = 16,
    parameter int CW = 13,
    parameter int LH = 4,
    parameter int LL = 3,
    parameter int LS = 2
) (
    input  logic          band_hi,
    input  logic [VW-1:0] val,
    output logic [CW-1:0] c_cnt,
    output logic [LH-LS-1:0] b_cnt,
    output logic [LS-1:0] a_cnt
);
    logic [LH-1:0] rem;

    always_comb begin
        if (band_hi) begin
            c_cnt = CW'(val >> LH);
            rem   = val[LH-1:0];
        end else begin
            c_cnt = CW'(val >> LL);
            rem   = LH'(val[LL-1:0]);
        end
        b_cnt = rem[LH-1:LS];
        a_cnt = rem[LS-1:0];
    end
endmodule

// File: rtl/fnd_legal.sv
module fnd_legal #(
    parameter int NW = 15,
    parameter int FW = 4,
    parameter int CW = 13,
    parameter int SW = 2,
    parameter int LS = 2
) (
    input  logic          band_hi,
    input  logic [NW-1:0] n_word,
    input  logic [FW-1:0] frac_num,
    input  logic [FW-1:0] den_code,
    input  logic [CW-1:0] c_cnt,
    input  logic [SW-1:0] b_cnt,
    input  logic [LS-1:0] a_cnt,
    output logic          ok,
    output logic [FW:0]   den_val
);
    localparam int HALF = 1 << (FW - 1);
    localparam int MW   = (SW > LS) ? SW : LS;

    logic          code_ok;
    logic [MW-1:0] mx;
    logic [CW-1:0] need;
    logic          range_ok;

    always_comb begin
        if (den_code == '0) begin
            den_val = (FW+1)'(1 << FW);
            code_ok = 1'b1;
        end else begin
            den_val = {1'b0, den_code};
            code_ok = (int'(den_code) > HALF);
        end
        mx       = (MW'(b_cnt) > MW'(a_cnt)) ? MW'(b_cnt) : MW'(a_cnt);
        need     = CW'(mx) + CW'(2);
        range_ok = band_hi || !n_word[NW-1];
        ok       = code_ok && ({1'b0, frac_num} < den_val) &&
                   (c_cnt >= need) && range_ok;
    end
endmodule

// File: rtl/fnd_accum.sv
module fnd_accum #(
    parameter int FW = 4
) (
    input  logic [FW-1:0] acc,
    input  logic [FW-1:0] frac_num,
    input  logic [FW:0]   den_val,
    output logic [FW-1:0] acc_nxt,
    output logic          ovf
);
    logic [FW:0] sum;

    always_comb begin
        sum     = {1'b0, acc} + {1'b0, frac_num};
        ovf     = (sum >= den_val);
        acc_nxt = ovf ? FW'(sum - den_val) : FW'(sum);
    end
endmodule

// File: rtl/fnd_top.sv
module fnd_top
    import fnd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          band_hi,
    input  logic [NW-1:0] n_word,
    input  logic [FW-1:0] frac_num,
    input  logic [FW-1:0] den_code,
    output logic          mod_p1,
    output logic          mod_p4,
    output logic          div_out,
    output logic          swallow,
    output logic          cfg_err
);
    dv_state_t     st_d, st_q;

    logic [CW-1:0] c_plain, c_eff;
    logic [SW-1:0] b_plain, b_eff;
    logic [LS-1:0] a_plain, a_eff;
    logic          cfg_ok;
    logic [FW:0]   den_val;
    logic [FW-1:0] acc_nxt;
    logic          ovf;
    logic [NW:0]   n_eff;
    logic          last_cyc;
    logic          run_w;

    // sub-counts of the programmed value, used for the legality rule
    fnd_split #(.VW(NW+1), .CW(CW), .LH(LH), .LL(LL), .LS(LS)) u_split_plain (
        .band_hi (band_hi),
        .val     ({1'b0, n_word}),
        .c_cnt   (c_plain),
        .b_cnt   (b_plain),
        .a_cnt   (a_plain)
    );

    fnd_legal #(.NW(NW), .FW(FW), .CW(CW), .SW(SW), .LS(LS)) u_legal (
        .band_hi  (band_hi),
        .n_word   (n_word),
        .frac_num (frac_num),
        .den_code (den_code),
        .c_cnt    (c_plain),
        .b_cnt    (b_plain),
        .a_cnt    (a_plain),
        .ok       (cfg_ok),
        .den_val  (den_val)
    );

    fnd_accum #(.FW(FW)) u_accum (
        .acc      (st_q.acc),
        .frac_num (frac_num),
        .den_val  (den_val),
        .acc_nxt  (acc_nxt),
        .ovf      (ovf)
    );

    // value actually divided next: N, or N + 1 on an accumulator wrap
    assign n_eff = {1'b0, n_word} + (NW+1)'(ovf);

    fnd_split #(.VW(NW+1), .CW(CW), .LH(LH), .LL(LL), .LS(LS)) u_split_eff (
        .band_hi (band_hi),
        .val     (n_eff),
        .c_cnt   (c_eff),
        .b_cnt   (b_eff),
        .a_cnt   (a_eff)
    );

    assign last_cyc = st_q.run && (st_q.k == st_q.c - CW'(1));

    always_comb begin
        st_d = st_q;
        if (!st_q.run || last_cyc) begin
            // division boundary (or idle): sample settings
            st_d.k = '0;
            if (cfg_ok) begin
                st_d.run = 1'b1;
                st_d.err = 1'b0;
                st_d.c   = c_eff;
                st_d.b   = b_eff;
                st_d.a   = a_eff;
                st_d.acc = acc_nxt;
                st_d.swl = ovf;
            end else begin
                st_d.run = 1'b0;
                st_d.err = 1'b1;
                st_d.swl = 1'b0;
            end
        end else begin
            st_d.k = st_q.k + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign mod_p1  = st_q.run && (st_q.k < CW'(st_q.a));
    assign mod_p4  = st_q.run && (st_q.k < CW'(st_q.b));
    assign div_out = last_cyc;
    assign swallow = st_q.swl;
    assign cfg_err = st_q.err;
    assign run_w   = st_q.run;

endmodule

// File: rtl/fnd_chk.sv
module fnd_chk (
    input logic clk,
    input logic rst,
    input logic run,
    input logic mod_p1,
    input logic mod_p4,
    input logic div_out,
    input logic swallow,
    input logic cfg_err
);
    assert_quiet_on_bad_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (!mod_p1 && !mod_p4 && !div_out));

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        div_out |=> !div_out);

    assert_reset_clears_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!div_out && !mod_p1 && !mod_p4 && !swallow && !cfg_err));

    assert_p1_no_mid_rise_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(mod_p1) |-> ($past(div_out) || !$past(run)));

    assert_p4_no_mid_rise_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(mod_p4) |-> ($past(div_out) || !$past(run)));

    assert_swallow_steady_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(div_out) && $past(run)) |-> $stable(swallow));

    assert_swallow_needs_run_R6: assert property (@(posedge clk) disable iff (rst)
        swallow |-> run);
endmodule

bind fnd_top fnd_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .run     (run_w),
    .mod_p1  (mod_p1),
    .mod_p4  (mod_p4),
    .div_out (div_out),
    .swallow (swallow),
    .cfg_err (cfg_err)
);

// File: tb/tb_fnd_top.sv
module tb_fnd_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        band_hi = 1'b1;
    logic [14:0] n_word = 15'd80;
    logic [3:0]  frac_num = 4'd0;
    logic [3:0]  den_code = 4'd0;
    logic        mod_p1, mod_p4, div_out, swallow, cfg_err;

    int checks = 0;
    int errors = 0;

    fnd_top dut (
        .clk(clk), .rst(rst), .band_hi(band_hi), .n_word(n_word),
        .frac_num(frac_num), .den_code(den_code), .mod_p1(mod_p1),
        .mod_p4(mod_p4), .div_out(div_out), .swallow(swallow), .cfg_err(cfg_err)
    );

    always #10 clk = ~clk;   // 50 MHz

    // {band_hi, N, numerator, denominator code}
    localparam int NV = 10;
    localparam logic [23:0] VT [NV] = '{
        {1'b1, 15'd80,    4'd0,  4'd0 },
        {1'b1, 15'd32767, 4'd15, 4'd0 },
        {1'b0, 15'd40,    4'd3,  4'd9 },
        {1'b0, 15'd16383, 4'd0,  4'd12},
        {1'b1, 15'd1000,  4'd7,  4'd13},
        {1'b0, 15'd123,   4'd5,  4'd15},
        {1'b1, 15'd95,    4'd1,  4'd10},
        {1'b0, 15'd47,    4'd11, 4'd14},
        {1'b0, 15'd24,    4'd0,  4'd9 },
        {1'b0, 15'd33,    4'd2,  4'd9 }
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic b, input int n, input int nu, input int de);
        band_hi  = b;
        n_word   = 15'(n);
        frac_num = 4'(nu);
        den_code = 4'(de);
    endtask

    task automatic pulse_reset;
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_pulse(output bit got);
        got = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (div_out) begin got = 1'b1; break; end
        end
    endtask

    // behavioural prescaler: oscillator cycles in one division
    task automatic measure(input int p, output int cnt, output bit sw);
        cnt = 0;
        sw  = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            cnt += p + int'(mod_p1) + 4 * int'(mod_p4);
            if (swallow) sw = 1'b1;
            if (div_out) break;
        end
    endtask

    task automatic chk_illegal(input logic b, input int n, input int nu, input int de,
                               input string req);
        int act;
        apply(b, n, nu, de);
        pulse_reset();
        repeat (3) @(negedge clk);
        chk(cfg_err == 1'b1, req, int'(cfg_err), 1);
        act = 0;
        repeat (40) begin
            @(negedge clk);
            if (div_out || mod_p1 || mod_p4) act++;
        end
        chk(act == 0, req, act, 0);
    endtask

    initial begin
        #(20 * 195000);
        errors++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic        vb;
        logic [14:0] vn;
        logic [3:0]  vnu, vde;
        int          p, dd, tot, sws, cnt, bad, nn, nu;
        bit          got, sw;
        logic [5:0]  p1b, p4b, pb;

        // R9: outputs clear while reset is held
        repeat (3) @(negedge clk);
        chk(!div_out && !mod_p1 && !mod_p4 && !swallow && !cfg_err,
            "R9 reset state", int'({div_out, mod_p1, mod_p4, swallow, cfg_err}), 0);

        // vector table: R1, R2, R4, R6, R7, R8
        for (int v = 0; v < NV; v++) begin
            {vb, vn, vnu, vde} = VT[v];
            nn = int'(vn);
            nu = int'(vnu);
            apply(vb, nn, nu, int'(vde));
            pulse_reset();
            p  = vb ? 16 : 8;
            dd = (vde == 4'd0) ? 16 : int'(vde);
            wait_pulse(got);
            tot = 0; sws = 0; bad = 0;
            for (int d = 0; d < dd; d++) begin
                measure(p, cnt, sw);
                tot += cnt;
                sws += int'(sw);
                if (cnt != nn + int'(sw)) bad++;
            end
            chk(bad == 0, "R1 per-division length", bad, 0);
            chk(tot == dd * nn + nu, "R2/R7 total over one accumulator period",
                tot, dd * nn + nu);
            if (nu == 0) chk(sws == 0, "R8 no swallow at zero numerator", sws, 0);
            else         chk(sws == nu, "R6 swallow count per period", sws, nu);
        end

        // R3 / R4 / R5: rejected settings
        chk_illegal(1'b1, 79,    0, 0,  "R4 base16 N=79");
        chk_illegal(1'b0, 39,    0, 0,  "R4 base8 N=39");
        chk_illegal(1'b0, 16384, 0, 0,  "R4 base8 N above 16383");
        chk_illegal(1'b0, 31,    0, 0,  "R3 C below max(A,B)+2");
        chk_illegal(1'b1, 200,   0, 5,  "R5 denominator code 5");
        chk_illegal(1'b1, 200,   0, 8,  "R5 denominator code 8");
        chk_illegal(1'b1, 200,   9, 9,  "R5 numerator not below modulus");

        // R3: recovery without reset
        apply(1'b1, 80, 0, 0);
        wait_pulse(got);
        chk(got && !cfg_err, "R3 recovery after legal setting", int'(got), 1);

        // R10: change N mid-division
        apply(1'b1, 2000, 0, 0);
        pulse_reset();
        wait_pulse(got);
        cnt = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            cnt += 16 + int'(mod_p1) + 4 * int'(mod_p4);
            if (i == 10) n_word = 15'd100;
            if (div_out) break;
        end
        chk(cnt == 2000, "R10 running division keeps old N", cnt, 2000);
        measure(16, cnt, sw);
        chk(cnt == 100, "R10 next division uses new N", cnt, 100);

        // R1 / R11: select pattern for N=107 base 16 (C=6, B=2, A=3)
        apply(1'b1, 107, 0, 0);
        pulse_reset();
        wait_pulse(got);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            p1b[i] = mod_p1;
            p4b[i] = mod_p4;
            pb[i]  = div_out;
        end
        begin
            logic [5:0] e1, e4;
            for (int i = 0; i < 6; i++) begin
                e1[i] = (i < (107 % 16) % 4);
                e4[i] = (i < (107 % 16) / 4);
            end
            chk(p1b == e1, "R1 plus-one select cycles", int'(p1b), int'(e1));
            chk(p4b == e4, "R1 plus-four select cycles", int'(p4b), int'(e4));
        end
        chk(pb == 6'b100000, "R11 pulse only in last cycle", int'(pb), 32);

        // R9: reset in the middle of a run
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        chk(!div_out && !mod_p1 && !mod_p4 && !swallow && !cfg_err,
            "R9 reset mid-run", int'({div_out, mod_p1, mod_p4, swallow, cfg_err}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule